// File: doc/BRIEF.md
# Vector Register-Group Layout Shuffler

This block permutes bytes between memory order and the layout that a group of vector registers uses. The layout follows a fixed rule that depends only on the element width and the group multiplier. A caller hands over one whole group at a time, up to four registers wide. The block then emits the group one register-sized beat per handshake, with a per-byte enable on each beat.

In load direction the input is contiguous memory data and each beat is one register of the group. With a multiplier above one, elements are dealt round-robin across the registers. With a multiplier below one, they are spread out with unwritten gaps between them. In store direction the input is the register group, and each beat is one register-width chunk of memory in element order. The store permutation is the exact inverse of the load permutation.

An unsupported width or multiplier code is accepted and dropped. It raises a one-cycle error pulse and produces no beats.

Top module: `vgs_shuffler`

## Requirements
- R1: Width code `in_sew` 0/1/2 selects 8/16/32-bit elements. Multiplier code `in_lmul` 3'b000/001/010 selects 1/2/4, and 3'b111/3'b110 select 1/2 and 1/4. With multiplier 1, a load emits the input's low VLEN bits unchanged with every byte enable high.
- R2: With multiplier M > 1 in load direction, element i (SEW/8 bytes, memory bytes i·SEW/8 upward) lands in beat i mod M at byte offset (i div M)·SEW/8.
- R3: With fractional multiplier 1/F in load direction, element i lands in beat 0 at byte offset i·F·SEW/8. Gap bytes have enable low and data zero.
- R4: In store direction, beat c byte b is memory byte c·VLEN/8 + b, taken from the register position that the load rule assigns to that byte. Only the first M·VLEN/8 memory bytes are enabled (VLEN/(8F) for fractional); disabled bytes carry zero. A load followed by a store of its result returns the original memory bytes.
- R5: A group gives max(M,1) beats with `out_idx` counting 0, 1, … in order. `out_last` is high only on the final beat, and no beat follows it.
- R6: Any other width or multiplier code is accepted and raises `err` for exactly the cycle after acceptance. No beat is produced.
- R7: After reset the block is idle with `in_ready` high and `out_valid` and `err` low. `in_ready` stays low while beats are pending. A beat held by `out_ready` low keeps its data, enables and index unchanged.
- R8: For multiplier 1 or below, element i always starts at byte i·(SEW/LMUL)/8. Equal SEW/LMUL ratios therefore place each element in the same aligned container at every width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | Block is idle and takes a group |
| in_store | input | 1 | 0 = memory-to-register, 1 = register-to-memory |
| in_sew | input | 2 | Element width code |
| in_lmul | input | 3 | Group multiplier code |
| in_data | input | 4·VLEN | Memory bytes (load) or registers 0..3 at VLEN each (store) |
| out_valid | output | 1 | A beat is present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | VLEN | Beat bytes |
| out_be | output | VLEN/8 | Per-byte enable |
| out_idx | output | 2 | Beat number within the group |
| out_last | output | 1 | Final beat of the group |
| err | output | 1 | Pulse for a rejected configuration |

## Verification
Two things can happen in the same cycle: a beat is held by back-pressure, and a new group is refused at the input. The bench stalls every beat for a cycle before taking it. During the stall it checks that `in_ready` is low and that the beat's bytes, enables and index do not move. All fifteen width and multiplier pairs are swept in both directions, against a model of the element placement rule. Each load result is fed back as a store to confirm that the original memory bytes return.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

   localparam int MAX_GRP = 4;

   typedef struct packed {
      logic       legal;
      logic       frac;
      logic [1:0] lsz;
      logic [1:0] lgrp;
   } geom_t;

   function automatic geom_t decode(input logic [1:0] sew, input logic [2:0] lmul);
      geom_t g;
      g.legal = 1'b1;
      g.frac  = 1'b0;
      g.lsz   = sew;
      g.lgrp  = 2'd0;
      if (sew == 2'd3) g.legal = 1'b0;
      case (lmul)
         3'b000:  g.lgrp = 2'd0;
         3'b001:  g.lgrp = 2'd1;
         3'b010:  g.lgrp = 2'd2;
         3'b111:  begin g.lgrp = 2'd1; g.frac = 1'b1; end
         3'b110:  begin g.lgrp = 2'd2; g.frac = 1'b1; end
         default: g.legal = 1'b0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/vgs_route.sv
module vgs_route #(
   parameter int VLEN = 128
) (
   input  logic [vgs_pkg::MAX_GRP*VLEN-1:0] grp,
   input  logic                             store,
   input  logic                             frac,
   input  logic [1:0]                       lsz,
   input  logic [1:0]                       lgrp,
   input  logic [1:0]                       beat,
   output logic [VLEN-1:0]                  data,
   output logic [VLEN/8-1:0]                be
);
   localparam int NB  = VLEN / 8;
   localparam int BW  = $clog2(NB);
   localparam int GB  = vgs_pkg::MAX_GRP * NB;
   localparam int GBW = $clog2(GB);

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [GBW-1:0] src;
      logic           ok;

      always_comb begin
         int unsigned ls, lg, slot, sub, elem, mb;
         ls   = 32'(lsz);
         lg   = 32'(lgrp);
         ok   = 1'b1;
         slot = 0;
         sub  = 0;
         elem = 0;
         mb   = 0;
         if (!store) begin
            if (!frac) begin
               slot = b >> ls;
               sub  = b & ((32'd1 << ls) - 1);
               elem = (slot << lg) + 32'(beat);
               mb   = (elem << ls) + sub;
            end else begin
               slot = b >> (ls + lg);
               sub  = b & ((32'd1 << (ls + lg)) - 1);
               ok   = (sub >> ls) == 0;
               mb   = (slot << ls) + sub;
            end
         end else begin
            mb   = (32'(beat) << BW) + b;
            elem = mb >> ls;
            sub  = mb & ((32'd1 << ls) - 1);
            if (!frac) begin
               mb = ((elem & ((32'd1 << lg) - 1)) << BW) + ((elem >> lg) << ls) + sub;
            end else begin
               ok = b < (NB >> lg);
               mb = (elem << (ls + lg)) + sub;
            end
         end
         src = GBW'(mb & (GB - 1));
      end

      assign data[b*8 +: 8] = ok ? grp[src*8 +: 8] : 8'h00;
      assign be[b]          = ok;
   end

endmodule

// File: rtl/vgs_ctrl.sv
module vgs_ctrl #(
   parameter int DW = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_store,
   input  vgs_pkg::geom_t in_geo,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_last,
   output logic [1:0]    beat,
   output logic          err,
   output logic [DW-1:0] grp_q,
   output logic          store_q,
   output logic          frac_q,
   output logic [1:0]    lsz_q,
   output logic [1:0]    lgrp_q
);
   logic       busy;
   logic       accept;
   logic [1:0] beat_max;

   assign accept    = in_valid && !busy;
   assign in_ready  = !busy;
   assign out_valid = busy;

   always_comb begin
      if (frac_q) beat_max = 2'd0;
      else begin
         case (lgrp_q)
            2'd0:    beat_max = 2'd0;
            2'd1:    beat_max = 2'd1;
            default: beat_max = 2'd3;
         endcase
      end
   end

   assign out_last = busy && (beat == beat_max);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         beat    <= 2'd0;
         err     <= 1'b0;
         store_q <= 1'b0;
         frac_q  <= 1'b0;
         lsz_q   <= 2'd0;
         lgrp_q  <= 2'd0;
      end else begin
         err <= accept && !in_geo.legal;
         if (accept && in_geo.legal) begin
            busy    <= 1'b1;
            beat    <= 2'd0;
            store_q <= in_store;
            frac_q  <= in_geo.frac;
            lsz_q   <= in_geo.lsz;
            lgrp_q  <= in_geo.lgrp;
         end else if (busy && out_ready) begin
            if (beat == beat_max) busy <= 1'b0;
            else                  beat <= beat + 2'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept && in_geo.legal) grp_q <= in_data;
   end

   AST_FRAC_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && frac_q) |-> out_last); // R5
   AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy); // R6

endmodule

// File: rtl/vgs_shuffler.sv
module vgs_shuffler #(
   parameter int VLEN = 128
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic                             in_store,
   input  logic [1:0]                       in_sew,
   input  logic [2:0]                       in_lmul,
   input  logic [vgs_pkg::MAX_GRP*VLEN-1:0] in_data,
   output logic                             out_valid,
   input  logic                             out_ready,
   output logic [VLEN-1:0]                  out_data,
   output logic [VLEN/8-1:0]                out_be,
   output logic [1:0]                       out_idx,
   output logic                             out_last,
   output logic                             err
);
   localparam int DW = vgs_pkg::MAX_GRP * VLEN;

   if (VLEN < 128 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two of at least 128");
   end

   vgs_pkg::geom_t geo;
   logic [DW-1:0]  grp_q;
   logic           store_q, frac_q;
   logic [1:0]     lsz_q, lgrp_q;

   assign geo = vgs_pkg::decode(in_sew, in_lmul);

   vgs_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store),
      .in_geo(geo), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
      .beat(out_idx), .err(err), .grp_q(grp_q),
      .store_q(store_q), .frac_q(frac_q), .lsz_q(lsz_q), .lgrp_q(lgrp_q)
   );

   vgs_route #(.VLEN(VLEN)) u_route (
      .grp(grp_q), .store(store_q), .frac(frac_q),
      .lsz(lsz_q), .lgrp(lgrp_q), .beat(out_idx),
      .data(out_data), .be(out_be)
   );

   AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be) && $stable(out_idx))); // R7
   AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R7
   AST_LAST_ENDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid); // R5
   AST_BEAT_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 2'd1)); // R5
   AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !out_valid); // R6
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R6

endmodule

// File: tb/tb_vgs_shuffler.sv
`timescale 1ns/1ps
module tb_vgs_shuffler;
   localparam int VLEN = 128;
   localparam int NB   = VLEN / 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic             in_store = 1'b0;
   logic [1:0]       in_sew = 2'd0;
   logic [2:0]       in_lmul = 3'd0;
   logic [4*VLEN-1:0] in_data = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [VLEN-1:0]  out_data;
   logic [NB-1:0]    out_be;
   logic [1:0]       out_idx;
   logic             out_last;
   logic             err;

   int tests = 0;
   int fails = 0;

   logic [VLEN-1:0] rd [4];
   logic [NB-1:0]   rb [4];
   logic [VLEN-1:0] xd [4];
   logic [NB-1:0]   xb [4];

   always #2.5 clk = ~clk;

   vgs_shuffler #(.VLEN(VLEN)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_store(in_store), .in_sew(in_sew), .in_lmul(in_lmul), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_be(out_be), .out_idx(out_idx), .out_last(out_last), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [4*VLEN-1:0] pat(input int t);
      logic [4*VLEN-1:0] v;
      for (int g = 0; g < 4 * NB; g++) v[g*8 +: 8] = 8'((g * 37 + t * 11 + 5) & 255);
      return v;
   endfunction

   function automatic logic [VLEN-1:0] bmask(input logic [NB-1:0] e);
      logic [VLEN-1:0] m;
      for (int b = 0; b < NB; b++) m[b*8 +: 8] = {8{e[b]}};
      return m;
   endfunction

   // Placement model: element i -> register (M>1 ? i mod M : 0), byte (i div M)*sb*F
   task automatic model(input bit st, input int sb, input int m, input int f,
                        input logic [4*VLEN-1:0] src);
      int nelem;
      nelem = (m * NB) / (sb * f);
      for (int j = 0; j < 4; j++) begin xd[j] = '0; xb[j] = '0; end
      for (int i = 0; i < nelem; i++) begin
         int j, n;
         j = (m > 1) ? i % m : 0;
         n = (i / m) * sb * f;
         for (int k = 0; k < sb; k++) begin
            int mb;
            mb = i * sb + k;
            if (!st) begin
               xd[j][(n+k)*8 +: 8] = src[mb*8 +: 8];
               xb[j][n+k] = 1'b1;
            end else begin
               xd[mb/NB][(mb%NB)*8 +: 8] = src[(j*NB+n+k)*8 +: 8];
               xb[mb/NB][mb%NB] = 1'b1;
            end
         end
      end
   endtask

   task automatic xfer(input bit st, input logic [1:0] sc, input logic [2:0] lc,
                       input logic [4*VLEN-1:0] bus, input int nexp, input string tag);
      logic [VLEN-1:0] d0;
      @(negedge clk);
      in_valid = 1'b1; in_store = st; in_sew = sc; in_lmul = lc; in_data = bus;
      @(posedge clk); #1;
      in_valid = 1'b0;
      for (int bt = 0; bt < nexp; bt++) begin
         @(negedge clk);
         out_ready = 1'b0;
         chk(out_valid, "R5", "beat present", VLEN'(out_valid), VLEN'(1));
         chk(!in_ready, "R7", "in_ready low while busy", VLEN'(in_ready), VLEN'(0));
         d0 = out_data;
         @(negedge clk);
         chk(out_data == d0, "R7", "stalled data held", out_data, d0);
         out_ready = 1'b1;
         rd[bt] = out_data;
         rb[bt] = out_be;
         chk(out_idx == 2'(bt), "R5", "beat index", VLEN'(out_idx), VLEN'(bt));
         chk(out_last == (bt == nexp - 1), tag, "last flag", VLEN'(out_last), VLEN'(bt == nexp - 1));
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(!out_valid, "R5", "no beat after last", VLEN'(out_valid), VLEN'(0));
   endtask

   task automatic compare(input int nexp, input string tag, input string what);
      for (int bt = 0; bt < nexp; bt++) begin
         chk(rb[bt] == xb[bt], tag, {what, " enables"}, VLEN'(rb[bt]), VLEN'(xb[bt]));
         chk(rd[bt] == xd[bt], tag, {what, " data"}, rd[bt], xd[bt]);
      end
   endtask

   task automatic bad_cfg(input logic [1:0] sc, input logic [2:0] lc);
      @(negedge clk);
      chk(in_ready, "R6", "idle before bad config", VLEN'(in_ready), VLEN'(1));
      in_valid = 1'b1; in_sew = sc; in_lmul = lc; in_data = pat(99);
      @(posedge clk); #1;
      in_valid = 1'b0;
      @(negedge clk);
      chk(err && !out_valid, "R6", "err pulse without beat", VLEN'({err, out_valid}), VLEN'(2'b10));
      @(negedge clk);
      chk(!err && !out_valid && in_ready, "R6", "err drops, still idle",
          VLEN'({err, out_valid, in_ready}), VLEN'(3'b001));
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [2:0] lcode [5];
      int         mm [5];
      int         ff [5];
      int         t;
      lcode = '{3'b110, 3'b111, 3'b000, 3'b001, 3'b010};
      mm    = '{1, 1, 1, 2, 4};
      ff    = '{4, 2, 1, 1, 1};
      t = 0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !out_valid && !err, "R7", "reset state",
          VLEN'({in_ready, out_valid, err}), VLEN'(3'b100));

      for (int sc = 0; sc < 3; sc++) begin
         for (int li = 0; li < 5; li++) begin
            logic [4*VLEN-1:0] mem, back, regs;
            string tag;
            int sb;
            sb  = 1 << sc;
            tag = (mm[li] > 1) ? "R2" : ((ff[li] > 1) ? "R3" : "R1");
            // load direction
            mem = pat(t); t++;
            model(1'b0, sb, mm[li], ff[li], mem);
            xfer(1'b0, 2'(sc), lcode[li], mem, mm[li], tag);
            compare(mm[li], tag, "load");
            if (mm[li] == 1) begin
               int ne, pos;
               ne  = NB / (sb * ff[li]);
               pos = (ne - 1) * sb * ff[li];
               chk(rd[0][pos*8 +: 8] == mem[(ne-1)*sb*8 +: 8], "R8", "last element container",
                   VLEN'(rd[0][pos*8 +: 8]), VLEN'(mem[(ne-1)*sb*8 +: 8]));
            end
            // round trip through store
            back = '0;
            for (int j = 0; j < mm[li]; j++) back[j*VLEN +: VLEN] = rd[j];
            model(1'b1, sb, mm[li], ff[li], back);
            xfer(1'b1, 2'(sc), lcode[li], back, mm[li], "R4");
            for (int c = 0; c < mm[li]; c++)
               chk((rd[c] & bmask(xb[c])) == (mem[c*VLEN +: VLEN] & bmask(xb[c])), "R4",
                   "round trip bytes", rd[c] & bmask(xb[c]), mem[c*VLEN +: VLEN] & bmask(xb[c]));
            // store direction on an independent pattern
            regs = pat(t); t++;
            model(1'b1, sb, mm[li], ff[li], regs);
            xfer(1'b1, 2'(sc), lcode[li], regs, mm[li], "R4");
            compare(mm[li], "R4", "store");
         end
      end

      bad_cfg(2'd3, 3'b000);
      bad_cfg(2'd0, 3'b011);
      bad_cfg(2'd1, 3'b100);
      bad_cfg(2'd2, 3'b101);

      // a legal group right after rejections still works
      begin
         logic [4*VLEN-1:0] mem;
         mem = pat(t);
         model(1'b0, 1, 1, 1, mem);
         xfer(1'b0, 2'd0, 3'b000, mem, 1, "R1");
         compare(1, "R1", "load after error");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule